// File: doc/BRIEF.md
# SD Data FIFO Byte Engine

This block sits between a 32-bit software data port and a byte-wide card data port. It carries block data through a small circular word FIFO. Software loads the transfer size as a block count and a block length, and picks the direction. The engine then moves one byte per clock at most over a valid/ready handshake with the card side.

In a read, card bytes are packed least-significant first into 32-bit words. Each finished word, and a zero-filled partial word at the end, enters the FIFO for software to pop. In a write, the engine fetches words that software has pushed and sends their bytes lowest byte first. It stops exactly when the byte count runs out.

The control is a four-state machine. The states are IDENT (code 0, after reset), RD (code 2), WR (code 3) and DATA (code 1). The transitions are:
- IDENT or DATA to RD or WR on a nonzero load, chosen by the direction input.
- RD to DATA on the final card byte received.
- WR to DATA on the final card byte sent.
- RD or WR to RD or WR on a nonzero reload.

The engine keeps sticky status flags, an interrupt line and a debug word that shows the state code and the live FIFO level.

Top module: `sdfe_byte_engine`

## Requirements
- R1: After reset the FIFO is empty, the byte count is zero, the state code is 0 (IDENT), `status` is zero, `irq` is low, `card_rx_ready` and `card_tx_valid` are low, and `sw_pop_data` is zero.
- R2: The FIFO holds 16 words of 32 bits and returns them in push order. A push while it holds 16 words is discarded. A pop while it is empty returns zero and leaves the level unchanged.
- R3: A pulse on `len_load` sets the remaining byte count to `blk_count * blk_len`. If the product is nonzero, the state becomes RD (code 2) when `dir_read` is 1, or WR (code 3) when it is 0. A zero product leaves the state code unchanged.
- R4: In RD, `card_rx_ready` is high only while the byte count is nonzero and the FIFO holds fewer than 16 words. Each accepted byte decrements the count by one.
- R5: The first byte of each group of four lands in bits 7:0, the next in 15:8, and so on. A completed word is pushed into the FIFO. When the count ends partway through a word, that word is pushed with its unfilled upper bytes zero.
- R6: In WR, a word is fetched from the FIFO whenever no bytes of the previous word are pending. Its bytes go out on `card_tx_data` starting with bits 7:0, one per `card_tx_valid`/`card_tx_ready` handshake. Each byte decrements the count. Bytes of a word left over when the count reaches zero are never sent.
- R7: Every word the engine moves sets `status` bit 0. If `data_irq_en` is high, it also sets bit 8. `irq` equals bit 8 OR bit 9. Software pushes and pops set no flag.
- R8: When the count reaches zero, the state code becomes 1 (DATA). Bit 9 of `status` is set at that point only if the transfer was a write and `block_irq_en` is high.
- R9: `dbg[8:4]` always shows the current FIFO level (0 to 16), and `dbg[3:0]` shows the state code.
- R10: Each bit of `status` that is 1 in `sts_clr` is cleared on that clock. All other bits keep their value.
- R11: When the engine and software want the same FIFO side in the same cycle, the engine wins. A software pop during an engine fetch returns zero and removes nothing. A software push during an engine push is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_push | input | 1 | Software writes one data word |
| sw_push_data | input | 32 | Word pushed by software |
| sw_pop | input | 1 | Software reads one data word |
| sw_pop_data | output | 32 | FIFO head, or zero when empty or when the engine is fetching |
| len_load | input | 1 | Load the byte count and start a transfer |
| blk_count | input | 9 | Number of blocks |
| blk_len | input | 10 | Bytes per block |
| dir_read | input | 1 | 1 selects card-to-FIFO, 0 selects FIFO-to-card |
| data_irq_en | input | 1 | Enables status bit 8 on word moves |
| block_irq_en | input | 1 | Enables status bit 9 at write completion |
| sts_clr | input | 10 | Write-one-to-clear mask for status |
| status | output | 10 | Bit 0 data moved, bit 8 data interrupt, bit 9 block interrupt |
| irq | output | 1 | Interrupt request |
| dbg | output | 9 | [8:4] FIFO level, [3:0] state code |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_ready | output | 1 | Engine accepts the card byte |
| card_tx_valid | output | 1 | Engine offers a byte to the card |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_ready | input | 1 | Card takes the byte |

## Verification
The assertions assume that `len_load` is not pulsed while a transfer is still moving bytes. They also assume that software does not push during a read, except in the one deliberate contention case. The stimulus starts every transfer with an empty FIFO and cleared status, and it gates software pops on the reported level, so pops never race a read. Card-side valid and ready are randomized each cycle, and the directed runs force the full-FIFO stall, a partial final word, unused bytes in a written word and an engine/software pop collision.

// File: rtl/sdfe_pkg.sv
`timescale 1ns/1ps
package sdfe_pkg;
    typedef enum logic [3:0] {
        ST_IDENT = 4'd0,
        ST_DATA  = 4'd1,
        ST_RD    = 4'd2,
        ST_WR    = 4'd3
    } sdfe_state_e;

    localparam int unsigned STS_W        = 10;
    localparam int unsigned STS_DATA_BIT = 0;
    localparam int unsigned STS_DIRQ_BIT = 8;
    localparam int unsigned STS_BIRQ_BIT = 9;
endpackage

// File: rtl/sdfe_word_fifo.sv
`timescale 1ns/1ps
module sdfe_word_fifo #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic [LW-1:0]     level,
    output logic              full,
    output logic              empty
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     rd_ptr;
    logic [AW-1:0]     wr_idx;
    logic              push_ok;
    logic              pop_ok;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign wr_idx  = rd_ptr + level[AW-1:0];
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_idx] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            rd_ptr <= rd_ptr + AW'(pop_ok);
            level  <= level + LW'(push_ok) - LW'(pop_ok);
        end
    end

    // R2: a push into a full FIFO with no pop leaves it full
    a_r2_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> (level == LW'(DEPTH)));

    // R2: a pop from an empty FIFO with no push leaves it empty
    a_r2_empty_pop_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> (level == '0));

    // R9: the level never exceeds the depth
    a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
endmodule

// File: rtl/sdfe_rx_pack.sv
`timescale 1ns/1ps
module sdfe_rx_pack #(
    parameter int WORD_W = 32,
    localparam int BPW   = WORD_W / 8,
    localparam int IW    = $clog2(BPW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              fire,
    input  logic              last,
    input  logic [7:0]        byte_in,
    output logic              word_done,
    output logic [WORD_W-1:0] word_out
);
    logic [WORD_W-1:0] acc;
    logic [IW-1:0]     idx;

    assign word_out  = acc | (WORD_W'(byte_in) << {idx, 3'b000});
    assign word_done = fire && ((idx == IW'(BPW - 1)) || last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            idx <= '0;
        end else if (clear) begin
            acc <= '0;
            idx <= '0;
        end else if (fire) begin
            if (word_done) begin
                acc <= '0;
                idx <= '0;
            end else begin
                acc <= word_out;
                idx <= idx + 1'b1;
            end
        end
    end

    // R5: a byte that does not finish a word leaves no bits above the next slot
    a_r5_partial_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !word_done && idx == '0) |=> (acc[WORD_W-1:8] == '0));
endmodule

// File: rtl/sdfe_tx_unpack.sv
`timescale 1ns/1ps
module sdfe_tx_unpack #(
    parameter int WORD_W = 32,
    localparam int BPW   = WORD_W / 8,
    localparam int IW    = $clog2(BPW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    output logic              has_byte,
    output logic [7:0]        byte_out
);
    logic [WORD_W-1:0] word;
    logic [IW:0]       left;

    assign has_byte = (left != '0);
    assign byte_out = word[7:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            left <= '0;
        end else if (clear) begin
            left <= '0;
        end else if (load) begin
            word <= load_word;
            left <= (IW+1)'(BPW);
        end else if (shift && has_byte) begin
            word <= word >> 8;
            left <= left - 1'b1;
        end
    end

    // R6: the byte after a sent byte is the next higher byte of the same word
    a_r6_low_byte_first: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clear && !load && left > (IW+1)'(1)) |=> (byte_out == $past(word[15:8])));
endmodule

// File: rtl/sdfe_byte_engine.sv
`timescale 1ns/1ps
module sdfe_byte_engine
    import sdfe_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int FIFO_DEPTH = 16,
    parameter int BLK_W      = 9,
    parameter int LEN_W      = 10,
    localparam int LW        = $clog2(FIFO_DEPTH + 1),
    localparam int CNT_W     = BLK_W + LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_push,
    input  logic [WORD_W-1:0] sw_push_data,
    input  logic              sw_pop,
    output logic [WORD_W-1:0] sw_pop_data,
    input  logic              len_load,
    input  logic [BLK_W-1:0]  blk_count,
    input  logic [LEN_W-1:0]  blk_len,
    input  logic              dir_read,
    input  logic              data_irq_en,
    input  logic              block_irq_en,
    input  logic [STS_W-1:0]  sts_clr,
    output logic [STS_W-1:0]  status,
    output logic              irq,
    output logic [LW+3:0]     dbg,
    input  logic              card_rx_valid,
    input  logic [7:0]        card_rx_data,
    output logic              card_rx_ready,
    output logic              card_tx_valid,
    output logic [7:0]        card_tx_data,
    input  logic              card_tx_ready
);
    sdfe_state_e       st_q, st_nx;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  load_val;
    logic              load_nz;
    logic              cnt_nz;
    logic              last_byte;
    logic              rx_fire;
    logic              tx_fire;
    logic              fetch;
    logic              word_moved;
    logic              tx_has;
    logic              rx_word_done;
    logic [WORD_W-1:0] rx_word;
    logic              fifo_push;
    logic [WORD_W-1:0] fifo_push_data;
    logic              fifo_pop;
    logic [WORD_W-1:0] fifo_head;
    logic [LW-1:0]     fifo_level;
    logic              fifo_full;
    logic              fifo_empty;
    logic [STS_W-1:0]  sts_set;

    assign load_val  = {{LEN_W{1'b0}}, blk_count} * {{BLK_W{1'b0}}, blk_len};
    assign load_nz   = (load_val != '0);
    assign cnt_nz    = (cnt_q != '0);
    assign last_byte = (cnt_q == CNT_W'(1));

    assign card_rx_ready = (st_q == ST_RD) && cnt_nz && !fifo_full && !len_load;
    assign fetch         = (st_q == ST_WR) && cnt_nz && !tx_has && !fifo_empty && !len_load;
    assign card_tx_valid = (st_q == ST_WR) && cnt_nz && tx_has && !len_load;
    assign rx_fire       = card_rx_valid && card_rx_ready;
    assign tx_fire       = card_tx_valid && card_tx_ready;
    assign word_moved    = rx_word_done || fetch;

    assign fifo_push      = rx_word_done || sw_push;
    assign fifo_push_data = rx_word_done ? rx_word : sw_push_data;
    assign fifo_pop       = fetch || sw_pop;
    assign sw_pop_data    = (fifo_empty || fetch) ? '0 : fifo_head;

    sdfe_word_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (fifo_push_data),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .level     (fifo_level),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    sdfe_rx_pack #(.WORD_W(WORD_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (len_load),
        .fire      (rx_fire),
        .last      (last_byte),
        .byte_in   (card_rx_data),
        .word_done (rx_word_done),
        .word_out  (rx_word)
    );

    sdfe_tx_unpack #(.WORD_W(WORD_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (len_load || (tx_fire && last_byte)),
        .load      (fetch),
        .load_word (fifo_head),
        .shift     (tx_fire),
        .has_byte  (tx_has),
        .byte_out  (card_tx_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDENT;
        end else begin
            st_q <= st_nx;
        end
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDENT, ST_DATA: begin
                if (len_load && load_nz) st_nx = dir_read ? ST_RD : ST_WR;
            end
            ST_RD: begin
                if (len_load) begin
                    if (load_nz) st_nx = dir_read ? ST_RD : ST_WR;
                end else if (rx_fire && last_byte) begin
                    st_nx = ST_DATA;
                end
            end
            ST_WR: begin
                if (len_load) begin
                    if (load_nz) st_nx = dir_read ? ST_RD : ST_WR;
                end else if (tx_fire && last_byte) begin
                    st_nx = ST_DATA;
                end
            end
            default: st_nx = ST_IDENT;
        endcase
    end

    // outputs and flag sets
    always_comb begin
        sts_set               = '0;
        sts_set[STS_DATA_BIT] = word_moved;
        sts_set[STS_DIRQ_BIT] = word_moved && data_irq_en;
        sts_set[STS_BIRQ_BIT] = tx_fire && last_byte && block_irq_en;
        irq                   = status[STS_DIRQ_BIT] || status[STS_BIRQ_BIT];
        dbg                   = {fifo_level, st_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            status <= '0;
        end else begin
            status <= (status & ~sts_clr) | sts_set;
            if (len_load) begin
                cnt_q <= load_val;
            end else if (rx_fire || tx_fire) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R4: no card byte is accepted while the FIFO is full
    a_r4_no_rx_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !card_rx_ready);

    // R3: a load sets the count to the product
    a_r3_count_load: assert property (@(posedge clk) disable iff (!rst_n)
        len_load |=> (cnt_q == $past(load_val)));

    // R8: the final byte moves the state to DATA
    a_r8_done_to_data: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_fire || tx_fire) && last_byte) |=> (st_q == ST_DATA));

    // R8: the block interrupt only rises at the end of a write
    a_r8_block_irq_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[STS_BIRQ_BIT]) |-> ($past(st_q) == ST_WR));

    // R11: a software pop during an engine fetch reads zero
    a_r11_fetch_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && sw_pop) |-> (sw_pop_data == '0));
endmodule

// File: tb/sdfe_byte_engine_test.sv
`timescale 1ns/1ps
module sdfe_byte_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_push = 1'b0;
    logic [31:0] sw_push_data = '0;
    logic        sw_pop = 1'b0;
    logic [31:0] sw_pop_data;
    logic        len_load = 1'b0;
    logic [8:0]  blk_count = '0;
    logic [9:0]  blk_len = '0;
    logic        dir_read = 1'b0;
    logic        data_irq_en = 1'b0;
    logic        block_irq_en = 1'b0;
    logic [9:0]  sts_clr = '0;
    logic [9:0]  status;
    logic        irq;
    logic [8:0]  dbg;
    logic        card_rx_valid = 1'b0;
    logic [7:0]  card_rx_data = '0;
    logic        card_rx_ready;
    logic        card_tx_valid;
    logic [7:0]  card_tx_data;
    logic        card_tx_ready = 1'b0;

    sdfe_byte_engine uut (
        .clk(clk), .rst_n(rst_n),
        .sw_push(sw_push), .sw_push_data(sw_push_data),
        .sw_pop(sw_pop), .sw_pop_data(sw_pop_data),
        .len_load(len_load), .blk_count(blk_count), .blk_len(blk_len),
        .dir_read(dir_read), .data_irq_en(data_irq_en), .block_irq_en(block_irq_en),
        .sts_clr(sts_clr), .status(status), .irq(irq), .dbg(dbg),
        .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
        .card_rx_ready(card_rx_ready),
        .card_tx_valid(card_tx_valid), .card_tx_data(card_tx_data),
        .card_tx_ready(card_tx_ready)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [7:0]  bytes  [0:255];
    logic [7:0]  rbytes [0:255];
    logic [31:0] words  [0:15];
    logic [31:0] got    [0:63];

    wire [4:0] lvl = dbg[8:4];
    wire [3:0] stc = dbg[3:0];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] exp_word(input int w, input int n);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++)
            if (4*w + k < n) r = r | (32'(bytes[4*w + k]) << (8*k));
        return r;
    endfunction

    task automatic clear_status;
        sts_clr = '1;
        tick;
        sts_clr = '0;
        chk(status == 0, "R10 clear all", status, 0);
    endtask

    task automatic run_read(input int bc, input int bl, input bit den, input bit hold);
        int n = bc * bl;
        int nw = (n + 3) / 4;
        int sent = 0;
        int popped = 0;
        int guard = 0;
        bit stall = 1'b0;
        bit fire;
        for (int i = 0; i < n; i++) bytes[i] = 8'($urandom);
        blk_count = 9'(bc); blk_len = 10'(bl); dir_read = 1'b1;
        data_irq_en = den; block_irq_en = 1'b1; len_load = 1'b1;
        tick;
        len_load = 1'b0;
        chk(stc == 4'd2, "R3 read state", stc, 2);
        while ((sent < n || popped < nw) && guard < 5000) begin
            guard++;
            card_rx_valid = (sent < n) && ($urandom % 4 != 0);
            card_rx_data  = (sent < n) ? bytes[sent] : 8'h00;
            sw_pop = (lvl != 0) && (!hold || stall || sent == n) && ($urandom % 3 != 0);
            #1;
            if (lvl == 5'd16 && card_rx_ready) chk(1'b0, "R4 ready while full", 1, 0);
            if (lvl == 5'd16 && !card_rx_ready && sent < n) stall = 1'b1;
            if (sw_pop) begin
                if (popped < 64) got[popped] = sw_pop_data;
                popped++;
            end
            fire = card_rx_valid && card_rx_ready;
            tick;
            if (fire) sent++;
        end
        card_rx_valid = 1'b0;
        sw_pop = 1'b0;
        chk(guard < 5000, "R4 read completes", guard, 5000);
        if (hold) chk(stall, "R4 stall at full FIFO", stall, 1);
        for (int w = 0; w < nw && w < 64; w++)
            chk(got[w] == exp_word(w, n), "R5 packed word", got[w], exp_word(w, n));
        chk(stc == 4'd1, "R8 data state after read", stc, 1);
        chk(status[0] == 1'b1, "R7 data flag", status[0], 1);
        chk(status[8] == den, "R7 data irq flag", status[8], den);
        chk(status[9] == 1'b0, "R8 no block irq on read", status[9], 0);
        chk(irq == den, "R7 irq line", irq, den);
        chk(card_rx_ready == 1'b0, "R4 no ready at zero count", card_rx_ready, 0);
        chk(lvl == 0, "R9 level drained", lvl, 0);
        if (den) begin
            sts_clr = 10'h001;
            tick;
            sts_clr = '0;
            chk(status == 10'h100, "R10 clear bit 0 only", status, 10'h100);
            chk(irq == 1'b1, "R7 irq follows bit 8", irq, 1);
        end
        clear_status;
    endtask

    task automatic run_write(input int nw, input int bc, input int bl,
                             input bit den, input bit ben, input bit contend);
        int n = bc * bl;
        int used = (n + 3) / 4;
        int rcv = 0;
        int guard = 0;
        logic [7:0] eb;
        for (int w = 0; w < nw; w++) begin
            words[w] = $urandom;
            sw_push = 1'b1;
            sw_push_data = words[w];
            tick;
        end
        sw_push = 1'b0;
        chk(lvl == 5'(nw), "R9 level after pushes", lvl, nw);
        chk(status == 0, "R7 software push sets no flag", status, 0);
        blk_count = 9'(bc); blk_len = 10'(bl); dir_read = 1'b0;
        data_irq_en = den; block_irq_en = ben; len_load = 1'b1;
        tick;
        len_load = 1'b0;
        chk(stc == 4'd3, "R3 write state", stc, 3);
        if (contend) begin
            sw_pop = 1'b1;
            #1;
            chk(sw_pop_data == 0, "R11 pop during fetch reads zero", sw_pop_data, 0);
            tick;
            sw_pop = 1'b0;
            chk(lvl == 5'(nw - 1), "R11 one word removed", lvl, nw - 1);
        end
        while (rcv < n && guard < 5000) begin
            guard++;
            card_tx_ready = ($urandom % 3 != 0);
            #1;
            if (card_tx_valid && card_tx_ready) begin
                rbytes[rcv] = card_tx_data;
                rcv++;
            end
            tick;
        end
        card_tx_ready = 1'b0;
        chk(guard < 5000, "R6 write completes", guard, 5000);
        card_tx_ready = 1'b1;
        tick;
        tick;
        chk(card_tx_valid == 1'b0, "R6 nothing after zero count", card_tx_valid, 0);
        card_tx_ready = 1'b0;
        for (int i = 0; i < n; i++) begin
            eb = 8'(words[i/4] >> (8*(i%4)));
            chk(rbytes[i] == eb, "R6 byte order", rbytes[i], eb);
        end
        chk(stc == 4'd1, "R8 data state after write", stc, 1);
        chk(status[9] == ben, "R8 block irq on write", status[9], ben);
        chk(status[0] == 1'b1, "R7 data flag on fetch", status[0], 1);
        chk(status[8] == den, "R7 data irq on fetch", status[8], den);
        chk(lvl == 5'(nw - used), "R9 leftover level", lvl, nw - used);
        for (int w = used; w < nw; w++) begin
            sw_pop = 1'b1;
            #1;
            chk(sw_pop_data == words[w], "R2 leftover order", sw_pop_data, words[w]);
            tick;
        end
        sw_pop = 1'b0;
        clear_status;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int nw;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(lvl == 0, "R1 level", lvl, 0);
        chk(stc == 4'd0, "R1 state", stc, 0);
        chk(status == 0, "R1 status", status, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        chk(!card_rx_ready && !card_tx_valid, "R1 card side idle", {card_rx_ready, card_tx_valid}, 0);
        chk(sw_pop_data == 0, "R1 pop data", sw_pop_data, 0);

        // R2: overfill and drain in the idle state
        for (int i = 0; i < 17; i++) begin
            sw_push = 1'b1;
            sw_push_data = $urandom;
            if (i < 16) words[i] = sw_push_data;
            tick;
        end
        sw_push = 1'b0;
        chk(lvl == 5'd16, "R2 full push discarded", lvl, 16);
        for (int i = 0; i < 16; i++) begin
            sw_pop = 1'b1;
            #1;
            chk(sw_pop_data == words[i], "R2 push order", sw_pop_data, words[i]);
            tick;
        end
        #1;
        chk(sw_pop_data == 0, "R2 underflow reads zero", sw_pop_data, 0);
        tick;
        sw_pop = 1'b0;
        chk(lvl == 0, "R2 underflow no change", lvl, 0);
        chk(status == 0, "R7 software pop sets no flag", status, 0);

        // directed reads and writes
        run_read(1, 7, 1'b1, 1'b0);
        run_read(2, 32, 1'b0, 1'b0);
        run_read(4, 20, 1'b1, 1'b1);
        run_write(3, 2, 5, 1'b1, 1'b1, 1'b1);
        run_write(5, 1, 9, 1'b0, 1'b0, 1'b0);
        run_write(16, 4, 16, 1'b1, 1'b1, 1'b0);

        // R3: a zero product leaves the state code unchanged
        blk_count = 9'd0; blk_len = 10'd12; dir_read = 1'b1; len_load = 1'b1;
        tick;
        len_load = 1'b0;
        chk(stc == 4'd1, "R3 zero load keeps state", stc, 1);

        // random transfers
        for (int r = 0; r < 4; r++) begin
            run_read(1 + int'($urandom % 4), 1 + int'($urandom % 25), 1'($urandom), 1'b0);
            nw = 1 + int'($urandom % 16);
            run_write(nw, 1, 1 + int'($urandom % (4 * nw)), 1'($urandom), 1'($urandom), 1'b0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule